// File: doc/BRIEF.md
# Flash Program/Erase Suspend Controller

This block models the suspend and resume control found inside a serial NOR flash device. It takes command strobes that have already been decoded: write enable, array program, array erase, read, suspend and resume. Each strobe comes with a sector address. From these it keeps a write enable latch and an 8-bit flag status register, and it decides whether a read may return valid data.

A program or erase starts only from idle with the latch set. It then stays busy for a fixed number of cycles. A suspend request is accepted only when enough of the operation is left to cover the suspend latency. The operation keeps running during that latency, then parks, and its remaining count is frozen until a resume arrives. A suspend that comes too late is refused, and the operation finishes on its original schedule.

While an erase is parked, the block polices requests by sector. A program to any other sector runs as a nested operation. A program to the parked sector is refused and raises a failure flag. A read of the parked sector is marked invalid.

Top module: `flash_suspend_ctrl`

## Requirements
- R1: After reset the flag register reads 0x80, ready is high, the write enable latch is 0, read-valid is 0, and no operation is active.
- R2: A write enable strobe sets the latch. A program or erase strobe starts an operation only from idle with the latch set; program wins if both arrive together. Starting clears the latch, and ready (flag bit 7) drops on the next edge.
- R3: A program keeps ready low for PROG_CYC clock edges after its start edge; an erase does the same for ERASE_CYC edges. Ready then returns high.
- R4: A suspend while busy is accepted when more than SUSP_LAT busy cycles remain after the request edge. On that edge, bit 2 (program) or bit 6 (erase) goes to 1. SUSP_LAT edges later bit 7 goes to 1 and the device is parked. Bits 2 and 6 are never both set.
- R5: A suspend that does not meet R4 still sets bit 2 or bit 6, but the operation completes at its original end edge and that bit is cleared there. A suspend on the final busy edge changes no flag.
- R6: A suspend arriving while idle, while parked, during the latency, or during a nested program changes no flag and no timing.
- R7: A resume while parked, with no nested program running, clears bits 7, 6 and 2. The operation continues from its frozen remaining count, so it ends after the time it had left. A resume in any other state is ignored.
- R8: While an erase is parked, a program to a different sector with the latch set is accepted. It clears the latch and holds bit 7 low for PROG_CYC edges, and the erase stays parked.
- R9: While an erase is parked, a program to the parked sector is ignored. Bit 4 goes to 1 and stays set until reset, and the latch keeps its value.
- R10: Read-valid is a one-cycle pulse on the edge after a read strobe. It is 1 when idle or parked, and 0 when busy, during the latency, during a nested program, or for the parked sector of a suspended erase.
- R11: A program without the latch set, and any program or erase while a program is parked, is ignored and changes no flag and not the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wren_i | input | 1 | Write enable strobe |
| prog_i | input | 1 | Array program strobe |
| erase_i | input | 1 | Sector erase strobe |
| read_i | input | 1 | Array read strobe |
| suspend_i | input | 1 | Suspend strobe |
| resume_i | input | 1 | Resume strobe |
| sector_i | input | SEC_W | Sector addressed by program, erase or read |
| fsr_o | output | 8 | Flag register: bit 7 ready, 6 erase parked, 4 program failure, 2 program parked |
| ready_o | output | 1 | Same as flag bit 7 |
| rd_valid_o | output | 1 | Read returned valid data |
| wel_o | output | 1 | Write enable latch |

## Verification
The following are checked on every cycle by the assertions:
- bits 2 and 6 are never set together;
- ready only rises with a suspend flag set when the latency has just run out or a nested program has just ended;
- a refused program to the parked sector leaves the latch as it was and raises bit 4;
- an idle suspend alters nothing, and a resume clears all three state bits;
- read-valid never appears without a read strobe.

Some behaviour can only be shown by the bench's sweeps. These include where the accept/refuse boundary falls for each suspend offset, and whether the remaining count is preserved across a park so that the operation ends exactly on time. Whether each sector of a parked erase reads valid or invalid is also shown only by the sweeps.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_PEND = 2'd2,
        ST_SUSP = 2'd3
    } fsc_state_e;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } fsc_op_e;

    localparam int FSR_RDY   = 7;
    localparam int FSR_ESUS  = 6;
    localparam int FSR_PFAIL = 4;
    localparam int FSR_PSUS  = 2;

endpackage

// File: rtl/fsc_countdown.sv
module fsc_countdown #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic [W-1:0] count_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (dec_i && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

    AST_LOAD_DEC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && dec_i)); // R3

endmodule

// File: rtl/fsc_sector_guard.sv
module fsc_sector_guard #(
    parameter int SEC_W = 3
) (
    input  logic             erase_parked_i,
    input  logic [SEC_W-1:0] parked_sector_i,
    input  logic [SEC_W-1:0] req_sector_i,
    output logic             blocked_o
);

    always_comb begin
        blocked_o = erase_parked_i && (req_sector_i == parked_sector_i);
    end

endmodule

// File: rtl/flash_suspend_ctrl.sv
module flash_suspend_ctrl
    import fsc_pkg::*;
#(
    parameter int PROG_CYC  = 12,
    parameter int ERASE_CYC = 40,
    parameter int SUSP_LAT  = 5,
    parameter int SECTORS   = 8,
    localparam int SEC_W    = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wren_i,
    input  logic             prog_i,
    input  logic             erase_i,
    input  logic             read_i,
    input  logic             suspend_i,
    input  logic             resume_i,
    input  logic [SEC_W-1:0] sector_i,
    output logic [7:0]       fsr_o,
    output logic             ready_o,
    output logic             rd_valid_o,
    output logic             wel_o
);

    localparam int MAX_OP  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int MAX_ALL = (MAX_OP > SUSP_LAT + 1) ? MAX_OP : SUSP_LAT + 1;
    localparam int CNT_W   = $clog2(MAX_ALL + 1);

    localparam logic [CNT_W-1:0] PROG_V  = CNT_W'(PROG_CYC);
    localparam logic [CNT_W-1:0] ERASE_V = CNT_W'(ERASE_CYC);
    localparam logic [CNT_W-1:0] LAT_V   = CNT_W'(SUSP_LAT);
    localparam logic [CNT_W-1:0] LAT_P1  = CNT_W'(SUSP_LAT + 1);
    localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

    typedef struct packed {
        fsc_state_e       st;
        fsc_op_e          op;
        logic [SEC_W-1:0] esec;
        logic             wel;
        logic             psus;
        logic             esus;
        logic             pfail;
        logic             rdv;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             rem_load, rem_dec;
    logic [CNT_W-1:0] rem_val, rem_cnt;
    logic             lat_load, lat_dec;
    logic [CNT_W-1:0] lat_cnt;
    logic             nest_load, nest_dec;
    logic [CNT_W-1:0] nest_cnt;
    logic             nest_busy;
    logic             blocked;

    fsc_countdown #(.W(CNT_W)) i_rem (
        .clk(clk), .rst_n(rst_n), .load_i(rem_load), .load_val_i(rem_val),
        .dec_i(rem_dec), .count_o(rem_cnt)
    );

    fsc_countdown #(.W(CNT_W)) i_lat (
        .clk(clk), .rst_n(rst_n), .load_i(lat_load), .load_val_i(LAT_V),
        .dec_i(lat_dec), .count_o(lat_cnt)
    );

    fsc_countdown #(.W(CNT_W)) i_nest (
        .clk(clk), .rst_n(rst_n), .load_i(nest_load), .load_val_i(PROG_V),
        .dec_i(nest_dec), .count_o(nest_cnt)
    );

    fsc_sector_guard #(.SEC_W(SEC_W)) i_guard (
        .erase_parked_i ((ctl_q.st == ST_SUSP) && (ctl_q.op == OP_ERASE)),
        .parked_sector_i(ctl_q.esec),
        .req_sector_i   (sector_i),
        .blocked_o      (blocked)
    );

    assign nest_busy = (nest_cnt != '0);

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.rdv = 1'b0;
        rem_load  = 1'b0;
        rem_val   = PROG_V;
        rem_dec   = 1'b0;
        lat_load  = 1'b0;
        lat_dec   = 1'b0;
        nest_load = 1'b0;
        nest_dec  = 1'b0;

        if (wren_i) ctl_d.wel = 1'b1;

        unique case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.rdv = read_i;
                if (prog_i && ctl_q.wel) begin
                    ctl_d.st  = ST_BUSY;
                    ctl_d.op  = OP_PROG;
                    ctl_d.wel = 1'b0;
                    rem_load  = 1'b1;
                    rem_val   = PROG_V;
                end else if (erase_i && ctl_q.wel) begin
                    ctl_d.st   = ST_BUSY;
                    ctl_d.op   = OP_ERASE;
                    ctl_d.esec = sector_i;
                    ctl_d.wel  = 1'b0;
                    rem_load   = 1'b1;
                    rem_val    = ERASE_V;
                end
            end
            ST_BUSY: begin
                rem_dec = 1'b1;
                if (rem_cnt == ONE_V) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.psus = 1'b0;
                    ctl_d.esus = 1'b0;
                end else if (suspend_i) begin
                    if (ctl_q.op == OP_PROG) ctl_d.psus = 1'b1;
                    else                     ctl_d.esus = 1'b1;
                    if (rem_cnt > LAT_P1) begin
                        ctl_d.st = ST_PEND;
                        lat_load = 1'b1;
                    end
                end
            end
            ST_PEND: begin
                rem_dec = 1'b1;
                lat_dec = 1'b1;
                if (lat_cnt == ONE_V) ctl_d.st = ST_SUSP;
            end
            ST_SUSP: begin
                if (nest_busy) begin
                    nest_dec = 1'b1;
                end else begin
                    ctl_d.rdv = read_i && !blocked;
                    if (resume_i) begin
                        ctl_d.st   = ST_BUSY;
                        ctl_d.psus = 1'b0;
                        ctl_d.esus = 1'b0;
                    end else if (prog_i && ctl_q.op == OP_ERASE) begin
                        if (blocked) begin
                            ctl_d.pfail = 1'b1;
                        end else if (ctl_q.wel) begin
                            ctl_d.wel = 1'b0;
                            nest_load = 1'b1;
                        end
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st    <= ST_IDLE;
            ctl_q.op    <= OP_PROG;
            ctl_q.esec  <= '0;
            ctl_q.wel   <= 1'b0;
            ctl_q.psus  <= 1'b0;
            ctl_q.esus  <= 1'b0;
            ctl_q.pfail <= 1'b0;
            ctl_q.rdv   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        ready_o            = ((ctl_q.st == ST_IDLE) || (ctl_q.st == ST_SUSP)) && !nest_busy;
        fsr_o              = 8'h00;
        fsr_o[FSR_RDY]     = ready_o;
        fsr_o[FSR_ESUS]    = ctl_q.esus;
        fsr_o[FSR_PFAIL]   = ctl_q.pfail;
        fsr_o[FSR_PSUS]    = ctl_q.psus;
        rd_valid_o         = ctl_q.rdv;
        wel_o              = ctl_q.wel;
    end

    AST_SUSP_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fsr_o[FSR_PSUS] && fsr_o[FSR_ESUS])); // R4

    AST_PARK_AFTER_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fsr_o[FSR_RDY]) && (fsr_o[FSR_PSUS] || fsr_o[FSR_ESUS]))
        |-> ($past(ctl_q.st) == ST_PEND || $past(nest_busy))); // R4

    AST_BLOCKED_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SUSP && !nest_busy && !resume_i && prog_i && blocked && !wren_i)
        |=> (fsr_o[FSR_PFAIL] && wel_o == $past(wel_o))); // R9

    AST_IDLE_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && suspend_i && !prog_i && !erase_i && !wren_i)
        |=> (fsr_o == $past(fsr_o) && wel_o == $past(wel_o))); // R6

    AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SUSP && !nest_busy && resume_i)
        |=> (!fsr_o[FSR_RDY] && !fsr_o[FSR_ESUS] && !fsr_o[FSR_PSUS])); // R7

    AST_RDV_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(read_i)); // R10

endmodule

// File: tb/test_flash_suspend_ctrl.sv
module test_flash_suspend_ctrl;

    localparam int PROG  = 12;
    localparam int ERASE = 40;
    localparam int LAT   = 5;
    localparam int SECS  = 8;
    localparam int SW    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wren_i = 1'b0, prog_i = 1'b0, erase_i = 1'b0;
    logic          read_i = 1'b0, suspend_i = 1'b0, resume_i = 1'b0;
    logic [SW-1:0] sector_i = '0;
    logic [7:0]    fsr_o;
    logic          ready_o, rd_valid_o, wel_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    flash_suspend_ctrl #(
        .PROG_CYC(PROG), .ERASE_CYC(ERASE), .SUSP_LAT(LAT), .SECTORS(SECS)
    ) i_flash_suspend_ctrl (
        .clk(clk), .rst_n(rst_n), .wren_i(wren_i), .prog_i(prog_i),
        .erase_i(erase_i), .read_i(read_i), .suspend_i(suspend_i),
        .resume_i(resume_i), .sector_i(sector_i), .fsr_o(fsr_o),
        .ready_o(ready_o), .rd_valid_o(rd_valid_o), .wel_o(wel_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic step(input logic w, input logic p, input logic e, input logic rd,
                        input logic s, input logic rs, input int sec);
        wren_i = w; prog_i = p; erase_i = e; read_i = rd;
        suspend_i = s; resume_i = rs; sector_i = sec[SW-1:0];
        @(negedge clk);
        wren_i = 0; prog_i = 0; erase_i = 0; read_i = 0;
        suspend_i = 0; resume_i = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        waitc(2);
        rst_n = 1'b1;
        waitc(1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 fsr", fsr_o, 8'h80);
        chk("R1 ready", ready_o, 1);
        chk("R1 wel", wel_o, 0);
        chk("R1 rdv", rd_valid_o, 0);

        // program timing, resume while busy ignored, read while busy invalid
        step(1,0,0,0,0,0,0);
        chk("R2 wel set", wel_o, 1);
        step(0,1,0,0,0,0,0);
        chk("R2 start fsr", fsr_o, 8'h00);
        chk("R2 wel clear", wel_o, 0);
        step(0,0,0,0,0,1,0);
        chk("R7 resume busy ignored", fsr_o, 8'h00);
        step(0,0,0,1,0,0,0);
        chk("R10 read busy", rd_valid_o, 0);
        waitc(PROG - 3);
        chk("R3 prog busy", fsr_o, 8'h00);
        waitc(1);
        chk("R3 prog done", fsr_o, 8'h80);
        chk("R3 ready", ready_o, 1);

        // erase timing
        step(1,0,0,0,0,0,0);
        step(0,0,1,0,0,0,2);
        waitc(ERASE - 1);
        chk("R3 erase busy", fsr_o, 8'h00);
        waitc(1);
        chk("R3 erase done", fsr_o, 8'h80);

        // program suspend sweep over every offset
        for (int d = 0; d < PROG; d++) begin
            int r;
            r = PROG - d;
            do_reset();
            step(1,0,0,0,0,0,0);
            step(0,1,0,0,0,0,1);
            waitc(d);
            step(0,0,0,0,1,0,0);
            if (r == 1) begin
                chk("R5 last edge suspend", fsr_o, 8'h80);
            end else if (r - 1 > LAT) begin
                int left;
                left = r - 1 - LAT;
                chk("R4 accept flag", fsr_o, 8'h04);
                waitc(LAT - 1);
                chk("R4 latency", fsr_o, 8'h04);
                waitc(1);
                chk("R4 parked", fsr_o, 8'h84);
                step(0,0,0,0,1,0,0);
                chk("R6 suspend parked", fsr_o, 8'h84);
                step(1,0,0,0,0,0,0);
                step(0,1,0,0,0,0,2);
                chk("R11 prog in prog park", fsr_o, 8'h84);
                chk("R11 wel kept", wel_o, 1);
                step(0,0,1,0,0,0,2);
                chk("R11 erase in prog park", fsr_o, 8'h84);
                step(0,0,0,1,0,0,1);
                chk("R10 read prog park", rd_valid_o, 1);
                step(0,0,0,0,0,1,0);
                chk("R7 resume flags", fsr_o, 8'h00);
                waitc(left - 1);
                chk("R7 still busy", fsr_o, 8'h00);
                waitc(1);
                chk("R7 completes", fsr_o, 8'h80);
            end else begin
                chk("R5 refused flag", fsr_o, 8'h04);
                waitc(PROG - 1 - d - 1);
                chk("R5 refused busy", fsr_o, 8'h04);
                waitc(1);
                chk("R5 refused done", fsr_o, 8'h80);
            end
        end

        // erase suspend with sector policing
        do_reset();
        step(1,0,0,0,0,0,0);
        step(0,0,1,0,0,0,3);
        step(0,0,0,0,1,0,0);
        chk("R4 erase flag", fsr_o, 8'h40);
        step(0,0,0,0,0,1,0);
        chk("R6 resume in latency", fsr_o, 8'h40);
        waitc(LAT - 1);
        chk("R4 erase parked", fsr_o, 8'hC0);
        for (int s = 0; s < SECS; s++) begin
            step(0,0,0,1,0,0,s);
            chk($sformatf("R10 read sector %0d", s), rd_valid_o, (s != 3) ? 1 : 0);
        end
        step(0,1,0,0,0,0,3);
        chk("R9 blocked no wel", fsr_o, 8'hD0);
        chk("R9 wel 0 kept", wel_o, 0);
        step(1,0,0,0,0,0,0);
        step(0,1,0,0,0,0,3);
        chk("R9 blocked fsr", fsr_o, 8'hD0);
        chk("R9 wel 1 kept", wel_o, 1);
        step(0,1,0,0,0,0,6);
        chk("R8 nested start", fsr_o, 8'h50);
        chk("R8 wel clear", wel_o, 0);
        step(0,0,0,1,0,0,6);
        chk("R10 read nested", rd_valid_o, 0);
        step(0,0,0,0,1,0,0);
        chk("R6 suspend nested", fsr_o, 8'h50);
        step(0,0,0,0,0,1,0);
        chk("R7 resume nested ignored", fsr_o, 8'h50);
        waitc(PROG - 4);
        chk("R8 nested busy", fsr_o, 8'h50);
        waitc(1);
        chk("R8 nested done", fsr_o, 8'hD0);
        step(0,0,0,0,0,1,0);
        chk("R7 erase resume", fsr_o, 8'h10);
        waitc(ERASE - 1 - LAT - 1);
        chk("R7 erase busy", fsr_o, 8'h10);
        waitc(1);
        chk("R7 erase done", fsr_o, 8'h90);

        // idle ignores
        do_reset();
        step(0,0,0,0,1,0,0);
        chk("R6 idle suspend", fsr_o, 8'h80);
        step(0,0,0,0,0,1,0);
        chk("R7 idle resume", fsr_o, 8'h80);
        step(0,1,0,0,0,0,0);
        chk("R11 prog no wel", fsr_o, 8'h80);
        step(0,0,1,0,0,0,0);
        chk("R11 erase no wel", fsr_o, 8'h80);
        step(0,0,0,1,0,0,4);
        chk("R10 idle read", rd_valid_o, 1);
        waitc(1);
        chk("R10 pulse ends", rd_valid_o, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule